// File: doc/BRIEF.md
# Fault Interrupt Status Controller

This block gathers three fault level signals from a power-stage monitor: over-current, over-voltage and thermal shutdown. Each fault is captured in a sticky status register, and the block drives an active-low, open-drain style interrupt line. The line is pulled low only while a captured fault has both its own enable bit and the global enable bit set in a separate enable register. The block does not contain the bus interface. It receives a single-cycle read strobe for the status register and a write strobe with data for the enable register, and it returns both registers as read data.

A read of the status register returns the captured value and clears it in the same clock edge. Any fault that is still active at that edge is captured again. Because of this re-capture, software sees a fresh interrupt event instead of a line that stays low. Clearing is blocked while the sleep-status input is high.

The interrupt output comes from a three-state machine:
- `IRQ_IDLE`: the line is released.
- `IRQ_DRIVE`: the line is pulled low.
- `IRQ_REARM`: a one-cycle release that follows a clearing read.

The machine has these transitions:
- IDLE→DRIVE when an enabled status bit is pending.
- DRIVE→IDLE when nothing enabled is pending.
- DRIVE→REARM on a clearing read.
- REARM→DRIVE if something enabled is pending, otherwise REARM→IDLE.

Top module: `fault_irq_ctrl`

## Requirements
- R1: After reset the status read data is 0x00, the enable read data is 0x00 and the interrupt line is released (`irq_pull_low` = 0).
- R2: A fault level that is high at a clock edge sets its status bit at that edge: `fault_in[2]` (over-current) sets bit 2, `fault_in[1]` (over-voltage) sets bit 1, `fault_in[0]` (thermal) sets bit 0. Status bits 7:3 always read 0.
- R3: A status bit stays set after its fault goes low, until a clearing read.
- R4: When `stat_rd` is high and `sleep_stat` is low, `stat_rdata` during that cycle shows the value held before the clear. After the edge, the status equals exactly the faults that were high at that edge.
- R5: A clearing read while the line is pulled low releases the line for exactly one cycle. If an enabled fault is still active, the line is pulled low again in the following cycle.
- R6: While `sleep_stat` is 1, a read leaves the status unchanged and does not release the line.
- R7: A write stores bit 7 (global enable) and bits 2:0 (per-fault enables, bit positions matching the status register). Bits 6:3 of the enable register always read 0.
- R8: The line is pulled low only if, in the previous cycle, the global enable was 1 and some status bit was 1 together with its own enable bit. When such a pending condition exists and no clearing read is under way, the line is pulled low one cycle later.
- R9: The line is released in the cycle after no enabled status bit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_in | input | 3 | Fault levels: [2] over-current, [1] over-voltage, [0] thermal |
| sleep_stat | input | 1 | Sleep status; blocks clearing reads while 1 |
| stat_rd | input | 1 | Single-cycle read strobe for the status register |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Write data for the enable register |
| stat_rdata | output | 8 | Status register read data |
| en_rdata | output | 8 | Enable register read data |
| irq_pull_low | output | 1 | 1 = pull the interrupt line low, 0 = release it |

## Verification
A status bit that is lost or stuck shows on `stat_rdata` at the next sample after the clock edge. It shows there even when the interrupt is masked, so the bench compares the status every cycle against a behavioural model. A wrong state in the interrupt machine shows on `irq_pull_low` within one cycle. A missing REARM release or a wrong gate under sleep differs from the model in the very cycle after the read. Random stretches that mix faults, enable writes, reads and sleep reach the combinations that the directed steps skip.

// File: rtl/fic_pkg.sv
package fic_pkg;
    // Interrupt line control states
    typedef enum logic [1:0] {
        IRQ_IDLE  = 2'd0,
        IRQ_DRIVE = 2'd1,
        IRQ_REARM = 2'd2
    } irq_state_e;

    // Status bit positions (decoded by software)
    localparam int BIT_TSD = 0;
    localparam int BIT_OVP = 1;
    localparam int BIT_OCP = 2;
endpackage

// File: rtl/fic_status_bank.sv
module fic_status_bank #(
    parameter int NUM_FAULTS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FAULTS-1:0] fault_lvl,
    input  logic                  clr_evt,
    output logic [NUM_FAULTS-1:0] sticky
);
    // One sticky flop per fault source; R2, R3, R4
    for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (clr_evt) begin
                bit_q <= fault_lvl[i];
            end else begin
                bit_q <= bit_q | fault_lvl[i];
            end
        end
        assign sticky[i] = bit_q;
    end
endmodule

// File: rtl/fic_enable_reg.sv
module fic_enable_reg #(
    parameter int DATA_W     = 8,
    parameter int NUM_FAULTS = 3,
    parameter int GLB_BIT    = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic                  glb_en,
    output logic [NUM_FAULTS-1:0] src_en
);
    localparam logic [DATA_W-1:0] EN_MASK =
        DATA_W'((1 << GLB_BIT) | ((1 << NUM_FAULTS) - 1));

    logic [DATA_W-1:0] en_q;

    // R7: only implemented bits are stored
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr) begin
            en_q <= wdata & EN_MASK;
        end
    end

    assign rdata  = en_q;
    assign glb_en = en_q[GLB_BIT];
    assign src_en = en_q[NUM_FAULTS-1:0];
endmodule

// File: rtl/fic_irq_fsm.sv
module fic_irq_fsm
    import fic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic clr_evt,
    output logic drive_low
);
    irq_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state; R5, R8, R9
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (pending) state_d = IRQ_DRIVE;
            end
            IRQ_DRIVE: begin
                if (clr_evt)       state_d = IRQ_REARM;
                else if (!pending) state_d = IRQ_IDLE;
            end
            IRQ_REARM: begin
                state_d = pending ? IRQ_DRIVE : IRQ_IDLE;
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        drive_low = 1'b0;
        unique case (state_q)
            IRQ_DRIVE: drive_low = 1'b1;
            IRQ_IDLE,
            IRQ_REARM: drive_low = 1'b0;
            default:   drive_low = 1'b0;
        endcase
    end
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl #(
    parameter int DATA_W     = 8,
    parameter int NUM_FAULTS = 3,
    parameter int GLB_BIT    = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FAULTS-1:0] fault_in,
    input  logic                  sleep_stat,
    input  logic                  stat_rd,
    input  logic                  en_wr,
    input  logic [DATA_W-1:0]     en_wdata,
    output logic [DATA_W-1:0]     stat_rdata,
    output logic [DATA_W-1:0]     en_rdata,
    output logic                  irq_pull_low
);
    localparam int PAD_W = DATA_W - NUM_FAULTS;

    logic                  clr_evt;
    logic [NUM_FAULTS-1:0] sticky;
    logic                  glb_en;
    logic [NUM_FAULTS-1:0] src_en;
    logic                  pending;

    // R4, R6: a read clears only when awake
    assign clr_evt = stat_rd & ~sleep_stat;

    fic_status_bank #(.NUM_FAULTS(NUM_FAULTS)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_lvl (fault_in),
        .clr_evt   (clr_evt),
        .sticky    (sticky)
    );

    fic_enable_reg #(
        .DATA_W     (DATA_W),
        .NUM_FAULTS (NUM_FAULTS),
        .GLB_BIT    (GLB_BIT)
    ) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (en_wr),
        .wdata  (en_wdata),
        .rdata  (en_rdata),
        .glb_en (glb_en),
        .src_en (src_en)
    );

    // R8: global and per-fault gating
    assign pending = glb_en & (|(sticky & src_en));

    fic_irq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .clr_evt   (clr_evt),
        .drive_low (irq_pull_low)
    );

    // R2: unused status bits read 0; value shown is pre-clear
    assign stat_rdata = {{PAD_W{1'b0}}, sticky};
endmodule

// File: rtl/fault_irq_ctrl_chk.sv
module fault_irq_ctrl_chk #(
    parameter int DATA_W     = 8,
    parameter int NUM_FAULTS = 3,
    parameter int GLB_BIT    = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_FAULTS-1:0] fault_in,
    input logic                  sleep_stat,
    input logic                  stat_rd,
    input logic [DATA_W-1:0]     stat_rdata,
    input logic [DATA_W-1:0]     en_rdata,
    input logic                  irq_pull_low
);
    logic port_pend;
    logic clr_rd;
    assign port_pend = en_rdata[GLB_BIT] &
                       (|(stat_rdata[NUM_FAULTS-1:0] & en_rdata[NUM_FAULTS-1:0]));
    assign clr_rd = stat_rd & ~sleep_stat;

    // R3
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((stat_rdata & $past(stat_rdata)) == $past(stat_rdata)));

    // R4
    stat_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rd |=> (stat_rdata[NUM_FAULTS-1:0] == $past(fault_in)));

    // R6
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && sleep_stat) |=> ((stat_rdata & $past(stat_rdata)) == $past(stat_rdata)));

    // R5
    rearm_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd && irq_pull_low) |=> !irq_pull_low);

    // R8
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pull_low) |-> $past(port_pend));

    // R9
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_pend |=> !irq_pull_low);

    // R2
    stat_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[DATA_W-1:NUM_FAULTS] == '0);
endmodule

bind fault_irq_ctrl fault_irq_ctrl_chk #(
    .DATA_W     (DATA_W),
    .NUM_FAULTS (NUM_FAULTS),
    .GLB_BIT    (GLB_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_in     (fault_in),
    .sleep_stat   (sleep_stat),
    .stat_rd      (stat_rd),
    .stat_rdata   (stat_rdata),
    .en_rdata     (en_rdata),
    .irq_pull_low (irq_pull_low)
);

// File: tb/sim_fault_irq_ctrl.sv
`timescale 1ns/1ps
module sim_fault_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] fault_in = '0;
    logic       sleep_stat = 1'b0;
    logic       stat_rd = 1'b0;
    logic       en_wr = 1'b0;
    logic [7:0] en_wdata = '0;
    logic [7:0] stat_rdata, en_rdata;
    logic       irq_pull_low;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;
    string cur_req = "R1";

    // behavioural reference
    int m_st = 0, m_en = 0;
    bit m_irq = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    fault_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .sleep_stat(sleep_stat),
        .stat_rd(stat_rd), .en_wr(en_wr), .en_wdata(en_wdata),
        .stat_rdata(stat_rdata), .en_rdata(en_rdata), .irq_pull_low(irq_pull_low)
    );

    always @(posedge clk) begin
        int  st_old;
        bit  pend, clr;
        if (!rst_n) begin
            m_st = 0; m_en = 0; m_irq = 1'b0;
        end else begin
            st_old = m_st;
            pend = ((m_en & 128) != 0) && ((st_old & m_en & 7) != 0);
            clr  = stat_rd && !sleep_stat;
            m_irq = m_irq ? (pend && !clr) : pend;
            m_st  = clr ? int'(fault_in) : (st_old | int'(fault_in));
            if (en_wr) m_en = int'(en_wdata) & 'h87;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cmp_on && rst_n) begin
            check(cur_req, int'(stat_rdata), m_st);
            check(cur_req, int'(en_rdata), m_en);
            check(cur_req, int'(irq_pull_low), int'(m_irq));
        end
    end

    // watchdog
    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic step(bit rd, bit wr, logic [7:0] wd, logic [2:0] f, bit slp);
        @(posedge clk); #2;
        stat_rd = rd; en_wr = wr; en_wdata = wd; fault_in = f; sleep_stat = slp;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 8'h00, 3'b000, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(stat_rdata), 0);
        check("R1", int'(en_rdata), 0);
        check("R1", int'(irq_pull_low), 0);
        cmp_on = 1'b1;

        cur_req = "R7";
        step(0, 1, 8'hFF, 3'b000, 0);
        idle(1);
        @(negedge clk); check("R7", int'(en_rdata), 'h87);

        cur_req = "R2";
        step(0, 0, 8'h00, 3'b100, 0);   // over-current one cycle
        idle(1);
        @(negedge clk); check("R2", int'(stat_rdata), 'h04);
        cur_req = "R8";
        idle(1);
        @(negedge clk); check("R8", int'(irq_pull_low), 1);
        cur_req = "R3";
        idle(3);
        @(negedge clk); check("R3", int'(stat_rdata), 'h04);

        cur_req = "R4";
        step(1, 0, 8'h00, 3'b000, 0);
        @(negedge clk); check("R4", int'(stat_rdata), 'h04);
        idle(1);
        @(negedge clk); check("R4", int'(stat_rdata), 0);
        cur_req = "R9";
        idle(2);
        @(negedge clk); check("R9", int'(irq_pull_low), 0);

        cur_req = "R5";
        step(0, 0, 8'h00, 3'b010, 0);
        step(0, 0, 8'h00, 3'b010, 0);
        step(0, 0, 8'h00, 3'b010, 0);
        step(1, 0, 8'h00, 3'b010, 0);   // clearing read, fault persists
        step(0, 0, 8'h00, 3'b010, 0);
        @(negedge clk); check("R5", int'(irq_pull_low), 0);
        check("R5", int'(stat_rdata), 'h02);
        step(0, 0, 8'h00, 3'b000, 0);
        @(negedge clk); check("R5", int'(irq_pull_low), 1);

        cur_req = "R6";
        step(1, 0, 8'h00, 3'b000, 1);
        step(0, 0, 8'h00, 3'b000, 1);
        @(negedge clk); check("R6", int'(stat_rdata), 'h02);
        check("R6", int'(irq_pull_low), 1);
        step(1, 0, 8'h00, 3'b000, 0);
        idle(3);

        cur_req = "R8";
        step(0, 1, 8'h01, 3'b000, 0);    // global enable off
        step(0, 0, 8'h00, 3'b001, 0);
        idle(2);
        @(negedge clk); check("R8", int'(irq_pull_low), 0);
        step(0, 1, 8'h81, 3'b100, 0);    // thermal only; over-current masked
        step(1, 0, 8'h00, 3'b000, 0);
        idle(3);
        @(negedge clk); check("R8", int'(irq_pull_low), 0);
        step(0, 0, 8'h00, 3'b001, 0);
        idle(2);
        @(negedge clk); check("R8", int'(irq_pull_low), 1);

        cur_req = "R2";
        for (int i = 0; i < 600; i++) begin
            automatic logic [31:0] r = $urandom;
            step(r[3:0] == 0, r[7:4] == 0, r[15:8], (r[19:16] < 3) ? r[22:20] : 3'b000,
                 r[26:24] == 0);
        end
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule